// File: doc/BRIEF.md
# GPIO Interrupt Cause Aggregator

This block produces the interrupt requests of a 32-line general-purpose I/O port. Its inputs are line values that have already been synchronised and polarity-corrected. Each line has two routes to an interrupt.

- **Level route.** The line value itself is the cause. A per-line level mask gates it.
- **Edge route.** A 0-to-1 transition of the line is caught in a sticky edge-cause register. A per-line edge mask gates it.

The two gated causes of a line are ORed together. The lines are then OR-reduced in groups of eight consecutive lines, which gives four registered summary requests for a downstream interrupt controller.

Software uses a small register port to reach the edge-cause register and both mask registers. An edge-cause bit is cleared by writing 0 to its position; writing 1 leaves it alone. Because the block only detects rising transitions of the corrected data, a line with polarity 0 reports its rising edges and a line with polarity 1 reports its falling edges. Catching both edges means toggling the polarity in software after each event.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `irq_group` is 0. Reads of the edge-cause, edge-mask and level-mask registers return 0 after reset.
- R2: The level route is not sticky. For a line whose level-mask bit is 1, its group output is 1 one clock after any clock edge at which the line is high. It is 0 again one clock after the line is sampled low, provided no other cause is active in that group.
- R3: An edge-cause bit is set at the clock edge where its line is sampled 1 and was sampled 0 at the previous clock edge. A line that stays high, or goes from 1 to 0, sets nothing.
- R4: Once set, an edge-cause bit stays 1 whatever the line does, until it is cleared by a write.
- R5: Writing with `reg_addr` = 0 clears every edge-cause bit whose `reg_wdata` bit is 0. Edge-cause bits whose `reg_wdata` bit is 1 keep their value.
- R6: When a new rising edge and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R7: The edge mask only gates the output. The edge-cause bit latches and reads back even when its edge-mask bit is 0. A set edge-cause bit drives its group output one clock after its edge-mask bit is 1.
- R8: `irq_group[g]` is the registered OR of the causes of lines 8g to 8g+7. The cause of line i is (line_in[i] & level_mask[i]) | (edge_cause[i] & edge_mask[i]). The output follows one clock after these values.
- R9: Register selection by `reg_addr`:
  - 0 selects the edge-cause register.
  - 1 selects the edge mask.
  - 2 selects the level mask.
  - 3 reads 0 and writes nothing.

  A write takes effect at the clock edge and is visible on the combinational `reg_rdata` afterwards.
- R10: A line already high when reset is released does not record an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 32 | Polarity-corrected, synchronised line values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 edge cause, 1 edge mask, 2 level mask, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_group | output | 4 | Registered summary request per group of eight lines |

## Verification
The line inputs are tried in several ways, each of which tells a different pair of behaviours apart:

- **Steady high levels** separate the non-sticky level route from the sticky edge route.
- **Single-cycle pulses** show that an edge is caught even after the line has dropped again.
- **Falling and held-high lines** show that only 0-to-1 transitions latch.
- **A clear write landing on the same edge as a new transition** settles the collision priority.
- **Lines spread across all four groups, with random masks**, confirm that each summary sees only its own eight lines.

Random line values and random register writes, run against a bench model, cover the interaction of all paths.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_EDGE_CAUSE = 2'd0,
    SEL_EDGE_MASK  = 2'd1,
    SEL_LEVEL_MASK = 2'd2,
    SEL_NONE       = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_edge_latch.sv
module gpio_irq_edge_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_keep,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q;

  function automatic logic [WIDTH-1:0] rising(input logic [WIDTH-1:0] cur,
                                              input logic [WIDTH-1:0] old);
    return cur & ~old;
  endfunction

  function automatic logic [WIDTH-1:0] next_cause(input logic [WIDTH-1:0] cur,
                                                  input logic             wr,
                                                  input logic [WIDTH-1:0] keep,
                                                  input logic [WIDTH-1:0] fresh);
    logic [WIDTH-1:0] kept;
    kept = wr ? (cur & keep) : cur;
    return kept | fresh;
  endfunction

  assign rise_o  = rising(din, prev_q);
  assign cause_o = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '1;
      cause_q <= '0;
    end else begin
      prev_q  <= din;
      cause_q <= next_cause(cause_q, clr_en, clr_keep, rise_o);
    end
  end
endmodule

// File: rtl/gpio_irq_mask_reg.sv
module gpio_irq_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_o <= '0;
    else if (wr_en) mask_o <= wdata;
  end
endmodule

// File: rtl/gpio_irq_group_reduce.sv
module gpio_irq_group_reduce #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = WIDTH / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      cause_i,
  output logic [NUM_GROUPS-1:0] group_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic any_w;
    assign any_w = |cause_i[g*GROUP_SIZE +: GROUP_SIZE];
    always_ff @(posedge clk) begin
      if (!rst_n) group_o[g] <= 1'b0;
      else        group_o[g] <= any_w;
    end
  end
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  line_in,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [NUM_LINES-1:0]  reg_wdata,
  output logic [NUM_LINES-1:0]  reg_rdata,
  output logic [NUM_GROUPS-1:0] irq_group
);
  import gpio_irq_pkg::*;

  reg_sel_e sel;
  logic [NUM_LINES-1:0] edge_cause, edge_mask, level_mask;
  logic [NUM_LINES-1:0] rise_vec, line_cause;
  logic wr_cause, wr_emask, wr_lmask;

  function automatic logic [NUM_LINES-1:0] merge(input logic [NUM_LINES-1:0] lvl,
                                                 input logic [NUM_LINES-1:0] lm,
                                                 input logic [NUM_LINES-1:0] ec,
                                                 input logic [NUM_LINES-1:0] em);
    return (lvl & lm) | (ec & em);
  endfunction

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_cause = reg_wr && (sel == SEL_EDGE_CAUSE);
  assign wr_emask = reg_wr && (sel == SEL_EDGE_MASK);
  assign wr_lmask = reg_wr && (sel == SEL_LEVEL_MASK);

  gpio_irq_edge_latch #(.WIDTH(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(line_in),
    .clr_en(wr_cause), .clr_keep(reg_wdata),
    .rise_o(rise_vec), .cause_o(edge_cause)
  );

  gpio_irq_mask_reg #(.WIDTH(NUM_LINES)) u_emask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_emask), .wdata(reg_wdata), .mask_o(edge_mask)
  );

  gpio_irq_mask_reg #(.WIDTH(NUM_LINES)) u_lmask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lmask), .wdata(reg_wdata), .mask_o(level_mask)
  );

  assign line_cause = merge(line_in, level_mask, edge_cause, edge_mask);

  gpio_irq_group_reduce #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_reduce (
    .clk(clk), .rst_n(rst_n), .cause_i(line_cause), .group_o(irq_group)
  );

  always_comb begin
    unique case (sel)
      SEL_EDGE_CAUSE: reg_rdata = edge_cause;
      SEL_EDGE_MASK:  reg_rdata = edge_mask;
      SEL_LEVEL_MASK: reg_rdata = level_mask;
      default:        reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_aggregator_chk.sv
module gpio_irq_aggregator_chk #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [1:0]            reg_addr,
  input logic [NUM_LINES-1:0]  reg_wdata,
  input logic [NUM_GROUPS-1:0] irq_group,
  input logic [NUM_LINES-1:0]  edge_cause,
  input logic [NUM_LINES-1:0]  edge_mask,
  input logic [NUM_LINES-1:0]  rise_vec,
  input logic [NUM_LINES-1:0]  line_cause
);
  logic [NUM_GROUPS-1:0] exp_grp;
  always_comb begin
    exp_grp = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (line_cause[i]) exp_grp[i / GROUP_SIZE] = 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> irq_group == '0);

  // R3
  edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((edge_cause & $past(rise_vec)) == $past(rise_vec)));

  // R4
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> ((edge_cause & $past(edge_cause)) == $past(edge_cause)));

  // R5
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      ((edge_cause & ~$past(reg_wdata) & ~$past(rise_vec)) == '0));

  // R8
  group_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_group == $past(exp_grp));

  // R9
  emask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> $stable(edge_mask));
endmodule

bind gpio_irq_aggregator gpio_irq_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_group(irq_group), .edge_cause(edge_cause),
  .edge_mask(edge_mask), .rise_vec(rise_vec), .line_cause(line_cause)
);

// File: tb/tb_gpio_irq_aggregator.sv
module tb_gpio_irq_aggregator;
  localparam int N = 32;
  localparam int G = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [G-1:0] irq_group;

  gpio_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_group(irq_group)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] m_ec, m_em, m_lm, m_prev;
  logic [G-1:0] m_sum;

  function automatic logic [G-1:0] model_groups(input logic [N-1:0] lv, input logic [N-1:0] lm,
                                                input logic [N-1:0] ec, input logic [N-1:0] em);
    logic [G-1:0] r = '0;
    for (int g = 0; g < G; g++)
      for (int k = 0; k < 8; k++) begin
        int b = g * 8 + k;
        if ((lv[b] && lm[b]) || (ec[b] && em[b])) r[g] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [N-1:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ec;
      2'd1: return m_em;
      2'd2: return m_lm;
      default: return '0;
    endcase
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(string tag);
    logic [N-1:0] er;
    checks++;
    if (irq_group !== m_sum) begin
      fails++;
      $display("FAIL %s irq_group actual %h expected %h", tag, irq_group, m_sum);
    end
    er = model_read(reg_addr);
    checks++;
    if (reg_rdata !== er) begin
      fails++;
      $display("FAIL %s reg_rdata[addr %0d] actual %h expected %h", tag, reg_addr, reg_rdata, er);
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] ec_n;
    @(posedge clk);
    if (!rst_n) begin
      m_ec = '0; m_em = '0; m_lm = '0; m_prev = '1; m_sum = '0;
    end else begin
      m_sum = model_groups(line_in, m_lm, m_ec, m_em);
      ec_n = m_ec;
      for (int i = 0; i < N; i++) begin
        if (reg_wr && reg_addr == 2'd0 && !reg_wdata[i]) ec_n[i] = 1'b0;
        if (line_in[i] && !m_prev[i]) ec_n[i] = 1'b1;
      end
      m_ec = ec_n;
      if (reg_wr && reg_addr == 2'd1) m_em = reg_wdata;
      if (reg_wr && reg_addr == 2'd2) m_lm = reg_wdata;
      m_prev = line_in;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(tag);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1 / R10: lines high through reset
    line_in = 32'h0000_00F0;
    for (int i = 0; i < 3; i++) step("R1 in reset");
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin reg_addr = 2'(a); step("R1 after reset"); end
    reg_addr = 2'd0;
    step("R10 high at release");
    // R9: mask registers and unused select
    wr(2'd1, 32'hA5A5_0F0F, "R9 edge mask write");
    reg_addr = 2'd1; step("R9 edge mask read");
    wr(2'd2, 32'h0000_0000, "R9 level mask write");
    wr(2'd3, 32'hFFFF_FFFF, "R9 select 3 write");
    reg_addr = 2'd3; step("R9 select 3 read");
    reg_addr = 2'd2; step("R9 level mask unchanged");
    wr(2'd1, 32'h0, "R9 edge mask zero");
    wr(2'd0, 32'h0, "R5 clear all");
    line_in = '0; step("R3 lines low");
    // R2: level route
    wr(2'd2, 32'h0000_0100, "R2 level mask set");
    line_in = 32'h0000_0100; step("R2 level high");
    step("R2 level held");
    line_in = 32'h0000_0000; step("R2 level low");
    step("R2 level gone");
    wr(2'd2, 32'h0, "R2 level mask clear");
    // R3 / R7: pulse with edge mask off, then enable
    reg_addr = 2'd0;
    wr(2'd0, 32'h0, "R5 clear");
    reg_addr = 2'd0;
    line_in = 32'h0001_0000; step("R3 single pulse");
    line_in = 32'h0; step("R4 after pulse");
    step("R7 latched unmasked");
    wr(2'd1, 32'h0001_0000, "R7 edge mask on");
    step("R7 group raised");
    // R3: falling and steady lines set nothing new
    line_in = 32'h8000_0000; step("R3 rise line 31");
    step("R3 steady high");
    line_in = 32'h0; step("R3 fall");
    // R5: write-one keeps, write-zero clears
    wr(2'd0, 32'h0001_0000, "R5 keep bit 16 clear 31");
    reg_addr = 2'd0; step("R5 readback");
    wr(2'd0, 32'h0, "R5 clear bit 16");
    step("R5 group low");
    // R6: edge and clear together
    line_in = 32'h0001_0000;
    wr(2'd0, 32'h0, "R6 edge beats clear");
    step("R6 bit still set");
    line_in = 32'h0;
    wr(2'd0, 32'h0, "R6 later clear");
    // R8: one line per group
    wr(2'd2, 32'h8040_2001, "R8 level mask spread");
    for (int g = 0; g < 4; g++) begin
      line_in = 32'h1 << (g * 8 + (g == 3 ? 7 : g == 2 ? 6 : g == 1 ? 5 : 0));
      step("R8 group select");
      step("R8 group hold");
    end
    line_in = 32'h0000_0002; step("R8 unmasked line");
    // R8: random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom(i + 7);
      line_in = $urandom();
      reg_addr = r[1:0];
      reg_wr = (r[4:2] == 3'd0);
      reg_wdata = $urandom();
      step("R8 random");
    end
    reg_wr = 1'b0;
    report();
  end
endmodule